// File: doc/BRIEF.md
# Register-Mapped MDIO Management Master

This block lets software run serial management transactions on a two-wire MDC/MDIO link through two 32-bit registers on a simple bus. The control register holds the MDC clock divisor, a preamble enable and a read-only completion flag. The data/command register takes a command word.

Writing a command word with its start bit set launches one frame, either a read or a write, with an optional preamble of ones. When the frame ends, the completion flag rises. For a read, the sampled 16-bit value is then in the low half of the data/command register.

A static input selects one of two command-word layouts. The newer layout has a 5-bit register field and a 5-bit device field. The legacy layout has a 4-bit register field and a 6-bit device field.

Software uses the block in a fixed sequence:
1. Program the control register.
2. Write the command word.
3. Poll the completion flag.
4. Read the result, if the frame was a read.
5. Write zero to the control register.

Top module: `mdio_mgmt_master`

## Requirements
- R1: Control register at offset 0x128. Bits [6:0] hold the divisor and bit 7 enables the preamble. Bit 8 is the completion flag: it is read-only, so writes to it are ignored. Writing zero clears the divisor and the preamble enable. After reset, the control register and the data/command register read 0, MDC is low, MDIO is not driven, and mdio_o is 1.
- R2: Data/command register at offset 0x12C. All 32 bits read back as written while idle. A write with bit 30 set while idle starts a frame. Bit 29 set selects a read; otherwise the frame is a write (bit 28). Bit 17 is stored but does not change the frame.
- R3: MDC stays low between frames. During a frame, MDC has a period of 2×(d+1) clock cycles, where d is the divisor, or 1 when the divisor is 0.
- R4: The frame is sent MSB first, with each bit held for one full MDC period and stable at the MDC rising edge. With preamble enabled, 32 ones come first. Then come the start bits 01, the opcode (01 for write, 10 for read), a 5-bit device address, a 5-bit register address, 2 turnaround bits and 16 data bits.
- R5: Newer layout (layout_legacy=0): the register address is taken from bits [22:18] and the device address from bits [27:23].
- R6: Legacy layout (layout_legacy=1): the register address is bits [21:18], zero-extended to 5 bits. The device field is bits [27:22], and its low five bits (bits [26:22]) are sent.
- R7: A write frame drives 10 during turnaround, then command bits [15:0]. The data/command register keeps the value written.
- R8: A read frame releases MDIO during turnaround and data. It samples mdio_i at the 16 data rising edges, MSB first, and writes the result into bits [15:0] at completion; bits [31:16] are kept.
- R9: The completion flag clears when a frame starts. It sets at the MDC falling edge that ends the last bit, and it is never set while a frame is running.
- R10: A data/command write during a frame is ignored entirely: the register keeps its value and no second frame follows.
- R11: The divisor and the preamble enable are captured at the start of a frame. Control writes during a frame do not change that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| layout_legacy | input | 1 | Selects the legacy command-word layout |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO input value |

## Verification
The assertions take for granted that layout_legacy only changes while no frame is running, and that bus writes are single-cycle strobes to one of the two offsets. The bench changes the layout only after the completion flag is set and before the next start. It issues every access through one-cycle write and read tasks, and it drives mdio_i as a device model that answers only in the read data window. Mid-frame disturbances are deliberate control and command writes, which the checks expect to be ignored.

// File: rtl/mdio_mgmt_master.sv
module mdio_mgmt_master #(
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] CTRL_OFS = 12'h128,
  parameter logic [ADDR_W-1:0] DATA_OFS = 12'h12C,
  parameter int DIV_W = 7,
  parameter int PRE_LEN = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              layout_legacy,
  output logic              mdc,
  output logic              mdio_o,
  output logic              mdio_oe,
  input  logic              mdio_i
);
  localparam int TOT   = PRE_LEN + 32;
  localparam int CNT_W = $clog2(TOT + 1);

  logic [DIV_W-1:0] div_q, half_q;
  logic             pre_q, done_q, busy, is_read, mdc_q;
  logic [31:0]      data_q, frame_q;
  logic [DIV_W:0]   tick_q;
  logic [CNT_W-1:0] bit_cnt;
  logic [15:0]      rsh_q;

  wire ctrl_wr = bus_wr && (bus_addr == CTRL_OFS);
  wire data_wr = bus_wr && (bus_addr == DATA_OFS);
  wire launch  = data_wr && !busy && bus_wdata[30];

  wire [DIV_W-1:0] div_eff = (div_q == '0) ? DIV_W'(1) : div_q;
  wire half_end = busy && (tick_q == {1'b0, half_q});
  wire rise = half_end && !mdc_q;
  wire fall = half_end && mdc_q;
  wire last_bit = (bit_cnt == CNT_W'(TOT - 1));
  wire in_pre = (bit_cnt < CNT_W'(PRE_LEN));
  wire [CNT_W-1:0] fpos = bit_cnt - CNT_W'(PRE_LEN);
  wire in_data = !in_pre && (fpos >= CNT_W'(16));
  wire released = is_read && !in_pre && (fpos >= CNT_W'(14));

  wire [4:0] phy_f = layout_legacy ? bus_wdata[26:22] : bus_wdata[27:23];
  wire [4:0] reg_f = layout_legacy ? {1'b0, bus_wdata[21:18]} : bus_wdata[22:18];
  wire [1:0] op_f  = bus_wdata[29] ? 2'b10 : 2'b01;
  wire [31:0] frame_d = {2'b01, op_f, phy_f, reg_f, 2'b10, bus_wdata[15:0]};

  assign mdc     = mdc_q;
  assign mdio_o  = !busy || in_pre || frame_q[5'd31 - fpos[4:0]];
  assign mdio_oe = busy && !released;

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == CTRL_OFS)
      bus_rdata = {{(31-DIV_W-1){1'b0}}, done_q, pre_q, div_q};
    else if (bus_addr == DATA_OFS)
      bus_rdata = data_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q   <= '0;
      pre_q   <= 1'b0;
      done_q  <= 1'b0;
      data_q  <= '0;
      busy    <= 1'b0;
      is_read <= 1'b0;
      mdc_q   <= 1'b0;
      half_q  <= '0;
      tick_q  <= '0;
      bit_cnt <= '0;
      frame_q <= '0;
      rsh_q   <= '0;
    end else begin
      if (ctrl_wr) begin
        div_q <= bus_wdata[DIV_W-1:0];
        pre_q <= bus_wdata[DIV_W];
      end
      if (data_wr && !busy)
        data_q <= bus_wdata;
      if (launch) begin
        busy    <= 1'b1;
        done_q  <= 1'b0;
        is_read <= bus_wdata[29];
        half_q  <= div_eff;
        tick_q  <= '0;
        mdc_q   <= 1'b0;
        bit_cnt <= pre_q ? '0 : CNT_W'(PRE_LEN);
        frame_q <= frame_d;
        rsh_q   <= '0;
      end else if (busy) begin
        tick_q <= half_end ? '0 : tick_q + 1'b1;
        if (half_end)
          mdc_q <= ~mdc_q;
        if (rise && is_read && in_data)
          rsh_q <= {rsh_q[14:0], mdio_i};
        if (fall) begin
          if (last_bit) begin
            busy   <= 1'b0;
            done_q <= 1'b1;
            if (is_read)
              data_q[15:0] <= rsh_q;
          end else begin
            bit_cnt <= bit_cnt + 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/mdio_mgmt_chk.sv
module mdio_mgmt_chk #(
  parameter int PRE_LEN = 32,
  parameter int CNT_W = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic             done_q,
  input logic             is_read,
  input logic             mdc,
  input logic             mdio_oe,
  input logic [CNT_W-1:0] bit_cnt,
  input logic [31:0]      frame_q
);
  // R3
  idle_mdc_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdc);
  // R9
  done_busy_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done_q));
  // R9
  done_after_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_q) |-> $fell(busy));
  // R8
  read_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && is_read && (bit_cnt >= CNT_W'(PRE_LEN + 14))) |-> !mdio_oe);
  // R7
  write_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !is_read) |-> mdio_oe);
  // R10
  frame_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(frame_q));
  // R3
  idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdio_oe);
endmodule

bind mdio_mgmt_master mdio_mgmt_chk #(.PRE_LEN(PRE_LEN), .CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done_q(done_q), .is_read(is_read),
  .mdc(mdc), .mdio_oe(mdio_oe), .bit_cnt(bit_cnt), .frame_q(frame_q)
);

// File: tb/mdio_mgmt_master_tb_top.sv
`timescale 1ns/1ps
module mdio_mgmt_master_tb_top;
  localparam logic [11:0] CTRL = 12'h128;
  localparam logic [11:0] DATA = 12'h12C;

  typedef struct {
    int          n;
    logic [63:0] val;
    logic [63:0] oe;
    int          per;
    string       req;
  } item_t;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [11:0] bus_addr = '0;
  logic bus_wr = 1'b0, layout_legacy = 1'b0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic mdc, mdio_o, mdio_oe, mdio_i;

  int total = 0, bad = 0;
  item_t exp_q[$];
  int seen = 0;
  logic [63:0] cap_v = '0, cap_oe = '0;
  realtime t_last = 0, t_prev = 0;
  bit cur_pre = 1'b0;
  logic [15:0] phy_val = '0;

  always #2.5 clk = ~clk;

  mdio_mgmt_master dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .layout_legacy(layout_legacy),
    .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  always_comb begin
    int base;
    base = cur_pre ? 32 : 0;
    mdio_i = 1'b1;
    if (seen >= base + 16 && seen < base + 32)
      mdio_i = phy_val[15 - (seen - base - 16)];
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  always @(posedge mdc) begin
    if (exp_q.size() == 0) begin
      chk(1'b0, "R10 unexpected frame", 64'(seen), 64'd0);
    end else begin
      cap_v  = {cap_v[62:0], mdio_o};
      cap_oe = {cap_oe[62:0], mdio_oe};
      t_prev = t_last;
      t_last = $realtime;
      seen++;
      if (seen == exp_q[0].n) begin
        chk(cap_oe === exp_q[0].oe, {exp_q[0].req, " drive enables"}, cap_oe, exp_q[0].oe);
        chk((cap_v & cap_oe) === (exp_q[0].val & exp_q[0].oe), {exp_q[0].req, " frame bits"},
            cap_v & cap_oe, exp_q[0].val & exp_q[0].oe);
        chk(int'((t_last - t_prev) / 5.0) == exp_q[0].per, "R3 mdc period",
            64'(int'((t_last - t_prev) / 5.0)), 64'(exp_q[0].per));
        void'(exp_q.pop_front());
        seen = 0;
        cap_v = '0;
        cap_oe = '0;
      end
    end
  end

  task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic do_frame(input string req, input bit pre, input logic [6:0] dv, input bit legacy,
                          input bit rd, input logic [5:0] dev, input logic [4:0] rg,
                          input logic [15:0] wd, input logic [15:0] rv, input bit disturb);
    logic [31:0] cmd, r;
    logic [4:0] phy5, reg5;
    logic [31:0] fw;
    item_t it;
    int dd, w;
    layout_legacy = legacy;
    bus_write(CTRL, {24'd0, pre, dv});
    cmd = 32'h4002_0000 | (rd ? 32'h2000_0000 : 32'h1000_0000) | {16'd0, wd};
    if (legacy) begin
      cmd |= {4'd0, dev, rg[3:0], 18'd0};
      phy5 = dev[4:0]; reg5 = {1'b0, rg[3:0]};
    end else begin
      cmd |= {4'd0, dev[4:0], rg, 18'd0};
      phy5 = dev[4:0]; reg5 = rg;
    end
    fw = {2'b01, rd ? 2'b10 : 2'b01, phy5, reg5, 2'b10, wd};
    it.n   = pre ? 64 : 32;
    it.val = pre ? {32'hFFFF_FFFF, fw} : {32'd0, fw};
    it.oe  = rd ? {32'hFFFF_FFFF, 14'h3FFF, 18'd0} : 64'hFFFF_FFFF_FFFF_FFFF;
    if (!pre) it.oe[63:32] = '0;
    dd = (dv == 0) ? 1 : int'(dv);
    it.per = 2 * (dd + 1);
    it.req = req;
    exp_q.push_back(it);
    cur_pre = pre;
    phy_val = rv;
    bus_write(DATA, cmd);
    bus_read(CTRL, r);
    chk(r[8] === 1'b0, "R9 done clear after start", 64'(r[8]), 64'd0);
    if (disturb) begin
      repeat (40) @(negedge clk);
      bus_write(CTRL, 32'h0000_0000);
      bus_write(DATA, 32'h7FFF_FFFF);
    end
    w = 0;
    do begin
      bus_read(CTRL, r);
      w++;
    end while (!r[8] && w < 20000);
    chk(r[8] === 1'b1, "R9 done set", 64'(r[8]), 64'd1);
    chk(exp_q.size() == 0, "R9 frame finished before done", 64'(exp_q.size()), 64'd0);
    bus_read(DATA, r);
    if (rd)
      chk(r === {cmd[31:16], rv}, "R8 read data", 64'(r), 64'({cmd[31:16], rv}));
    else
      chk(r === cmd, "R7 data register kept", 64'(r), 64'(cmd));
    if (!disturb) begin
      bus_read(CTRL, r);
      chk(r === {23'd0, 1'b1, pre, dv}, "R1 control readback", 64'(r), 64'({23'd0, 1'b1, pre, dv}));
    end
    bus_write(CTRL, 32'h0000_01FF);
    bus_write(CTRL, 32'h0000_0000);
    bus_read(CTRL, r);
    chk(r === 32'h100, "R1 control cleared", 64'(r), 64'h100);
    repeat (5) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog", 64'd0, 64'd1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    bus_read(CTRL, r);
    chk(r === 32'd0, "R1 reset ctrl", 64'(r), 64'd0);
    bus_read(DATA, r);
    chk(r === 32'd0, "R1 reset data", 64'(r), 64'd0);
    chk({mdc, mdio_oe, mdio_o} === 3'b001, "R1 reset pins", 64'({mdc, mdio_oe, mdio_o}), 64'd1);
    bus_write(DATA, 32'h1234_5678);
    bus_read(DATA, r);
    chk(r === 32'h1234_5678, "R2 idle readback no start", 64'(r), 64'h1234_5678);
    chk(exp_q.size() == 0 && !mdc, "R2 no frame without start", 64'(mdc), 64'd0);
    // R4 R5 R7: newer layout write with preamble
    do_frame("R5 write new", 1'b1, 7'd2, 1'b0, 1'b0, 6'h15, 5'h1F, 16'hA5C3, 16'h0, 1'b0);
    // R3: divisor 0 treated as 1, no preamble
    do_frame("R3 div0 write", 1'b0, 7'd0, 1'b0, 1'b0, 6'h01, 5'h02, 16'h0F0F, 16'h0, 1'b0);
    // R8: read, newer layout
    do_frame("R8 read new", 1'b1, 7'd1, 1'b0, 1'b1, 6'h1D, 5'h01, 16'h0000, 16'hBEEF, 1'b0);
    // R6: legacy layout, dev bit5 set, 4-bit reg
    do_frame("R6 write legacy", 1'b0, 7'd3, 1'b1, 1'b0, 6'h2B, 5'h0A, 16'h1357, 16'h0, 1'b0);
    do_frame("R6 read legacy", 1'b1, 7'd2, 1'b1, 1'b1, 6'h3F, 5'h0F, 16'hFFFF, 16'h6C81, 1'b0);
    // R10 R11: disturbing writes mid-frame
    do_frame("R11 disturbed write", 1'b1, 7'd5, 1'b0, 1'b0, 6'h07, 5'h11, 16'h8001, 16'h0, 1'b1);
    repeat (800) @(negedge clk);
    chk(exp_q.size() == 0 && seen == 0, "R10 no extra frame", 64'(seen), 64'd0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule